// File: doc/BRIEF.md
# Shared Input Stream Distributor

This block feeds one input token stream to a group of pages. The states that read the stream are split across those pages, and only one page is active at any time. The block keeps the order in which the tokens are consumed equal to the order in which they arrive. It also tracks which page is active and uses that page to merge the per-page output lanes back into one ordered stream.

A two-bit mode input picks the distribution policy. In broadcast mode every token is offered to all pages. Each page ignores arriving tokens while its discard counter is non-zero. The counters are loaded with each activation and count down once per token. Request mode passes one token to the active page for each read request that page raises. Prefetch mode fills a one-entry holding slot for the page named by the prefetch target. That page receives the held token as soon as it is active.

Top module: `shared_stream_dist`

## Requirements
- R1: In broadcast mode (mode_i 0, and also 3) in_ready_o is always 1. An accepted token appears on pg_dat_o one cycle later. It appears on every pg_vld_o bit whose page had a zero discard count at the accepting edge.
- R2: Activation loads discard counts from act_skip_i. Page p uses bits [p*CW +: CW]. Each broadcast token lowers a non-zero count by one, and a page gets the token only while its count is zero.
- R3: When an activation and a token fall on the same edge, the token is judged with the old counts and the old active page. The new values apply from the next edge.
- R4: In request mode (mode_i 1), req_i bit p counts only when p is the active page. A request raised at edge n makes in_ready_o high after that edge. The token taken at edge n+1 appears at pg_vld_o bit p after edge n+1, so one request releases one token. A new request arriving on the edge that takes a token keeps the next read pending.
- R5: A request made with no token present stays pending until a token arrives. The token is then delivered with no new request.
- R6: In prefetch mode (mode_i 2), a token is taken only while the holding slot of page pf_page_i is empty, and it is placed in that slot. in_ready_o is 0 while that slot is full.
- R7: A held token is sent on pg_vld_o and pg_dat_o one cycle after its page becomes active. This happens at the edge after the activation edge, and it empties the slot.
- R8: The collector registers the lane of the active page. col_vld_o and col_dat_o follow lane_vld_i and lane_dat_i of that page one cycle later, and lanes of inactive pages have no effect.
- R9: In request and prefetch modes at most one page receives a token per cycle. The tokens received across all pages equal the input sequence, with none lost and none duplicated.
- R10: After reset pg_vld_o and col_vld_o are 0, page 0 is active, no request is pending, all discard counts are zero and all slots are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | 0/3 broadcast, 1 request, 2 prefetch |
| act_valid_i | input | 1 | Activation strobe |
| act_page_i | input | PW | Page that becomes active |
| act_skip_i | input | NPAGE*CW | Per-page discard counts loaded by activation |
| pf_page_i | input | PW | Prefetch target page |
| req_i | input | NPAGE | Per-page read request |
| in_valid_i | input | 1 | Input token valid |
| in_data_i | input | DW | Input token |
| in_ready_o | output | 1 | Input token accepted when high with valid |
| pg_vld_o | output | NPAGE | Per-page token delivery strobe |
| pg_dat_o | output | DW | Delivered token |
| lane_vld_i | input | NPAGE | Per-page output lane valid |
| lane_dat_i | input | NPAGE*DW | Per-page output lane data |
| col_vld_o | output | 1 | Merged output valid |
| col_dat_o | output | DW | Merged output data |

## Verification
An activation can land on the same edge as a token. In broadcast mode the bench drives the two together as one vector row. It then expects delivery under the old counts and old active page, and expects the new counts to govern only the next token. In request mode a fresh request can coincide with the edge that consumes the previous one. The bench raises the request twice in a row and expects two tokens on consecutive cycles, with nothing lost. A sequence monitor confirms the order across pages.

// File: rtl/sd_pkg.sv
package sd_pkg;
    typedef enum logic [1:0] {
        SD_BCAST  = 2'd0,
        SD_REQ    = 2'd1,
        SD_PREF   = 2'd2,
        SD_BCAST2 = 2'd3
    } sd_mode_e;
endpackage

// File: rtl/sd_page_slot.sv
// Per-page state: broadcast discard counter and one-entry prefetch slot.
module sd_page_slot #(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] skip_i,
    input  logic          tick_i,
    input  logic          fill_i,
    input  logic          drain_i,
    input  logic [DW-1:0] dat_i,
    output logic          open_o,
    output logic          full_o,
    output logic [DW-1:0] hold_o
);
    typedef struct packed {
        logic [CW-1:0] skip;
        logic          full;
        logic [DW-1:0] hold;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick_i && s_q.skip != '0) s_d.skip = s_q.skip - 1'b1;
        if (load_i)  s_d.skip = skip_i;
        if (drain_i) s_d.full = 1'b0;
        if (fill_i) begin
            s_d.full = 1'b1;
            s_d.hold = dat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign open_o = (s_q.skip == '0);
    assign full_o = s_q.full;
    assign hold_o = s_q.hold;
endmodule

// File: rtl/sd_collector.sv
// Merges per-page output lanes by following the active page.
module sd_collector #(
    parameter int NPAGE = 4,
    parameter int DW    = 8,
    localparam int PW   = $clog2(NPAGE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PW-1:0]       act_i,
    input  logic [NPAGE-1:0]    lane_vld_i,
    input  logic [NPAGE*DW-1:0] lane_dat_i,
    output logic                vld_o,
    output logic [DW-1:0]       dat_o
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } col_t;

    col_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.vld = lane_vld_i[act_i];
        if (lane_vld_i[act_i]) c_d.dat = lane_dat_i[act_i*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign vld_o = c_q.vld;
    assign dat_o = c_q.dat;
endmodule

// File: rtl/shared_stream_dist.sv
module shared_stream_dist
    import sd_pkg::*;
#(
    parameter int NPAGE = 4,
    parameter int DW    = 8,
    parameter int CW    = 4,
    localparam int PW   = $clog2(NPAGE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                act_valid_i,
    input  logic [PW-1:0]       act_page_i,
    input  logic [NPAGE*CW-1:0] act_skip_i,
    input  logic [PW-1:0]       pf_page_i,
    input  logic [NPAGE-1:0]    req_i,
    input  logic                in_valid_i,
    input  logic [DW-1:0]       in_data_i,
    output logic                in_ready_o,
    output logic [NPAGE-1:0]    pg_vld_o,
    output logic [DW-1:0]       pg_dat_o,
    input  logic [NPAGE-1:0]    lane_vld_i,
    input  logic [NPAGE*DW-1:0] lane_dat_i,
    output logic                col_vld_o,
    output logic [DW-1:0]       col_dat_o
);
    typedef struct packed {
        logic [PW-1:0]    act;
        logic             pend;
        logic [NPAGE-1:0] vld;
        logic [DW-1:0]    dat;
    } dist_t;

    dist_t st_d, st_q;

    sd_mode_e         mode;
    logic             is_bc;
    logic             take;
    logic [NPAGE-1:0] open_w;
    logic [NPAGE-1:0] full_w;
    logic [DW-1:0]    hold_w [NPAGE];

    assign mode  = sd_mode_e'(mode_i);
    assign is_bc = (mode == SD_BCAST) || (mode == SD_BCAST2);

    always_comb begin
        case (mode)
            SD_REQ:  in_ready_o = st_q.pend;
            SD_PREF: in_ready_o = ~full_w[pf_page_i];
            default: in_ready_o = 1'b1;
        endcase
    end

    assign take = in_valid_i & in_ready_o;

    for (genvar p = 0; p < NPAGE; p++) begin : g_slot
        sd_page_slot #(.DW(DW), .CW(CW)) i_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (act_valid_i),
            .skip_i (act_skip_i[p*CW +: CW]),
            .tick_i (is_bc & take),
            .fill_i ((mode == SD_PREF) & take & (pf_page_i == PW'(p))),
            .drain_i((mode == SD_PREF) & (st_q.act == PW'(p)) & full_w[p]),
            .dat_i  (in_data_i),
            .open_o (open_w[p]),
            .full_o (full_w[p]),
            .hold_o (hold_w[p])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = '0;
        st_d.pend = 1'b0;
        case (mode)
            SD_REQ: begin
                if (take) begin
                    st_d.vld[st_q.act] = 1'b1;
                    st_d.dat           = in_data_i;
                end
                st_d.pend = (st_q.pend & ~take) | req_i[st_q.act];
            end
            SD_PREF: begin
                if (full_w[st_q.act]) begin
                    st_d.vld[st_q.act] = 1'b1;
                    st_d.dat           = hold_w[st_q.act];
                end
            end
            default: begin
                if (take) begin
                    st_d.vld = open_w;
                    st_d.dat = in_data_i;
                end
            end
        endcase
        if (act_valid_i) begin
            st_d.act  = act_page_i;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pg_vld_o = st_q.vld;
    assign pg_dat_o = st_q.dat;

    sd_collector #(.NPAGE(NPAGE), .DW(DW)) i_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (st_q.act),
        .lane_vld_i(lane_vld_i),
        .lane_dat_i(lane_dat_i),
        .vld_o     (col_vld_o),
        .dat_o     (col_dat_o)
    );
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
    parameter int NPAGE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             in_valid_i,
    input logic             in_ready_o,
    input logic [NPAGE-1:0] pg_vld_o,
    input logic [NPAGE-1:0] full_w
);
    // R1: broadcast never back-pressures
    a_r1_bcast_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 || mode_i == 2'd3) |-> in_ready_o);

    // R4: a request-mode delivery follows an accepted token
    a_r4_req_from_take: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && $past(mode_i) == 2'd1 && pg_vld_o != '0)
        |-> $past(in_valid_i && in_ready_o));

    // R6: a slot only fills from an accepted token, one slot at a time
    a_r6_fill_from_take: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2 && $past(mode_i) == 2'd2 && (full_w & ~$past(full_w)) != '0)
        |-> $past(in_valid_i && in_ready_o));

    a_r6_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(full_w & ~$past(full_w)) <= 1);

    // R9: directed modes deliver to at most one page
    a_r9_single_page: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == 2'd1 || $past(mode_i) == 2'd2) |-> $onehot0(pg_vld_o));
endmodule

bind shared_stream_dist sd_checker #(.NPAGE(NPAGE)) i_sd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o),
    .pg_vld_o  (pg_vld_o),
    .full_w    (full_w)
);

// File: tb/test_shared_stream_dist.sv
module test_shared_stream_dist;
    localparam int NPAGE = 4;
    localparam int DW    = 8;
    localparam int CW    = 4;
    localparam int PW    = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          mode = '0;
    logic                act_valid = 1'b0;
    logic [PW-1:0]       act_page = '0;
    logic [NPAGE*CW-1:0] act_skip = '0;
    logic [PW-1:0]       pf_page = '0;
    logic [NPAGE-1:0]    req = '0;
    logic                in_valid = 1'b0;
    logic [DW-1:0]       in_data = '0;
    logic                in_ready;
    logic [NPAGE-1:0]    pg_vld;
    logic [DW-1:0]       pg_dat;
    logic [NPAGE-1:0]    lane_vld = '0;
    logic [NPAGE*DW-1:0] lane_dat = '0;
    logic                col_vld;
    logic [DW-1:0]       col_dat;

    int total = 0;
    int bad   = 0;
    int rx_n  = 0;
    int rx_bad = 0;
    int seq_exp = 1;

    always #10 clk = ~clk;

    shared_stream_dist #(.NPAGE(NPAGE), .DW(DW), .CW(CW)) i_shared_stream_dist (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .act_valid_i(act_valid), .act_page_i(act_page), .act_skip_i(act_skip),
        .pf_page_i(pf_page), .req_i(req),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
        .pg_vld_o(pg_vld), .pg_dat_o(pg_dat),
        .lane_vld_i(lane_vld), .lane_dat_i(lane_dat),
        .col_vld_o(col_vld), .col_dat_o(col_dat)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R9 order monitor for the directed modes
    always @(negedge clk) begin
        if (rst_n && mode != 2'd0 && pg_vld != '0) begin
            rx_n++;
            if (pg_dat != DW'(seq_exp) || $countones(pg_vld) != 1) rx_bad++;
            seq_exp++;
        end
    end

    // {actv, page[2], skip[16], tokv, dat[8], exp_vld[4]}
    localparam logic [31:0] VEC [9] = '{
        {1'b1, 2'd0, 16'hFF30, 1'b0, 8'd0, 4'b0000},
        {1'b0, 2'd0, 16'h0000, 1'b1, 8'd1, 4'b0001},
        {1'b0, 2'd0, 16'h0000, 1'b1, 8'd2, 4'b0001},
        {1'b0, 2'd0, 16'h0000, 1'b1, 8'd3, 4'b0001},
        {1'b0, 2'd0, 16'h0000, 1'b1, 8'd4, 4'b0011},
        {1'b1, 2'd1, 16'hFF0F, 1'b0, 8'd0, 4'b0000},
        {1'b0, 2'd0, 16'h0000, 1'b1, 8'd5, 4'b0010},
        {1'b1, 2'd2, 16'hF0FF, 1'b1, 8'd6, 4'b0010},
        {1'b0, 2'd0, 16'h0000, 1'b1, 8'd7, 4'b0100}
    };

    initial begin
        #(20 * 50000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk(pg_vld == '0, "R10 pg_vld", int'(pg_vld), 0);
        chk(col_vld == 1'b0, "R10 col_vld", int'(col_vld), 0);
        chk(in_ready == 1'b1, "R10 R1 bcast ready", int'(in_ready), 1);
        mode = 2'd1;
        #1;
        chk(in_ready == 1'b0, "R10 no pending request", int'(in_ready), 0);
        mode = 2'd0;

        // R1 R2 R3 broadcast vectors
        for (int i = 0; i < 9; i++) begin
            act_valid = VEC[i][31];
            act_page  = VEC[i][30:29];
            act_skip  = VEC[i][28:13];
            in_valid  = VEC[i][12];
            in_data   = VEC[i][11:4];
            @(negedge clk);
            chk(pg_vld == VEC[i][3:0], "R1 R2 R3 vector vld", int'(pg_vld), int'(VEC[i][3:0]));
            if (VEC[i][3:0] != 4'b0000)
                chk(pg_dat == VEC[i][11:4], "R1 vector data", int'(pg_dat), int'(VEC[i][11:4]));
        end
        act_valid = 1'b0;
        in_valid  = 1'b0;
        @(negedge clk);

        // R4 request mode, active page 2
        mode = 2'd1;
        act_valid = 1'b1; act_page = 2'd2;
        @(negedge clk);
        act_valid = 1'b0;
        in_valid = 1'b1; in_data = 8'd1;
        #1;
        chk(in_ready == 1'b0, "R4 no request no ready", int'(in_ready), 0);
        req = 4'b0010;
        @(negedge clk);
        req = '0;
        chk(in_ready == 1'b0, "R4 inactive request ignored", int'(in_ready), 0);
        @(negedge clk);
        chk(pg_vld == '0, "R4 inactive request no token", int'(pg_vld), 0);
        req = 4'b0100;
        @(negedge clk);
        req = '0;
        chk(in_ready == 1'b1, "R4 request pending", int'(in_ready), 1);
        chk(pg_vld == '0, "R4 round trip", int'(pg_vld), 0);
        @(negedge clk);
        chk(pg_vld == 4'b0100 && pg_dat == 8'd1, "R4 delivery", int'({pg_vld, pg_dat}), 'h401);
        chk(in_ready == 1'b0, "R4 one token per request", int'(in_ready), 0);

        // R5 stall until token
        in_valid = 1'b0; in_data = 8'd2;
        req = 4'b0100;
        @(negedge clk);
        req = '0;
        repeat (3) @(negedge clk);
        chk(pg_vld == '0 && in_ready == 1'b1, "R5 stalled request", int'({pg_vld, in_ready}), 1);
        in_valid = 1'b1;
        @(negedge clk);
        chk(pg_vld == 4'b0100 && pg_dat == 8'd2, "R5 late token", int'({pg_vld, pg_dat}), 'h402);

        // R4 request coinciding with a take
        in_data = 8'd3;
        req = 4'b0100;
        @(negedge clk);
        @(negedge clk);
        chk(pg_vld == 4'b0100 && pg_dat == 8'd3, "R4 first of pair", int'({pg_vld, pg_dat}), 'h403);
        req = '0; in_data = 8'd4;
        @(negedge clk);
        chk(pg_vld == 4'b0100 && pg_dat == 8'd4, "R4 second of pair", int'({pg_vld, pg_dat}), 'h404);
        in_valid = 1'b0;
        @(negedge clk);

        // R6 R7 prefetch
        mode = 2'd2;
        act_valid = 1'b1; act_page = 2'd0;
        @(negedge clk);
        act_valid = 1'b0;
        pf_page = 2'd1; in_valid = 1'b1; in_data = 8'd5;
        #1;
        chk(in_ready == 1'b1, "R6 empty slot ready", int'(in_ready), 1);
        @(negedge clk);
        in_data = 8'd6;
        chk(in_ready == 1'b0, "R6 full slot stalls", int'(in_ready), 0);
        @(negedge clk);
        chk(pg_vld == '0, "R7 held while inactive", int'(pg_vld), 0);
        act_valid = 1'b1; act_page = 2'd1;
        @(negedge clk);
        act_valid = 1'b0;
        chk(pg_vld == '0, "R7 not before activation edge", int'(pg_vld), 0);
        @(negedge clk);
        chk(pg_vld == 4'b0010 && pg_dat == 8'd5, "R7 forward on activation", int'({pg_vld, pg_dat}), 'h205);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(pg_vld == 4'b0010 && pg_dat == 8'd6, "R6 refill and forward", int'({pg_vld, pg_dat}), 'h206);
        @(negedge clk);
        chk(rx_n == 6 && rx_bad == 0, "R9 order across pages", rx_n * 16 + rx_bad, 6 * 16);

        // R8 collector
        mode = 2'd0;
        act_valid = 1'b1; act_page = 2'd3; act_skip = '0;
        @(negedge clk);
        act_valid = 1'b0;
        lane_vld = 4'b1001;
        lane_dat = {8'h77, 8'h00, 8'h00, 8'h11};
        @(negedge clk);
        chk(col_vld == 1'b1 && col_dat == 8'h77, "R8 active lane", int'({col_vld, col_dat}), 'h177);
        lane_vld = 4'b0001;
        @(negedge clk);
        chk(col_vld == 1'b0, "R8 inactive lane ignored", int'(col_vld), 0);
        lane_vld = '0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule